// File: doc/BRIEF.md
# Processor Exception Control Unit

This block manages exception entry and return for a small 32-bit in-order core. The pipeline raises one-cycle request strobes together with the PC of the offending instruction: a data bus fault (an unmapped address or a misaligned access), an unsigned divide or modulo, a system call and a breakpoint. Only one request is taken per cycle. The taken request produces a redirect to a vectored handler address and a write of the faulting PC into a return-address register. It also saves the interrupt-enable bit into a slot that belongs to that class of event.

The block also holds four control registers: interrupt enable, interrupt pending, exception base and debug base. They are reached through a small CSR read/write port. When the core executes a branch through a return-address register, the unit restores the saved enable bit. Decode, the register file and the arithmetic datapath live elsewhere; only their handshakes appear here.

Top module: `trap_ctrl`

## Requirements
- R1: A taken non-breakpoint exception produces, on the clock edge after the request, a one-cycle redirect pulse. The redirect PC is the exception base plus cause times 32, and the register-file write targets register 30 with the faulting PC. Cause codes: 1 breakpoint, 4 data bus error, 5 divide by zero, 7 system call.
- R2: On a non-breakpoint exception, interrupt enable (3 bits) becomes its old bit 0 placed in bit 1, with bits 0 and 2 cleared.
- R3: A taken breakpoint redirects to the debug base plus 32 and writes the faulting PC to register 31.
- R4: On a breakpoint, interrupt enable becomes its old bit 0 placed in bit 2, with bits 0 and 1 cleared.
- R5: A return through register 30 sets interrupt enable to its old bit 1 in bit 0, with the other bits cleared. A return through register 31 does the same with old bit 2. A return through any other register leaves interrupt enable unchanged.
- R6: Interrupt lines set pending bits. A CSR write to the pending register clears each bit written as 1 and keeps each bit written as 0. A line that is active in the same cycle as a clear of its bit leaves that bit set.
- R7: CSR select codes are 0 enable, 1 pending, 2 exception base and 3 debug base. Writes to every register other than pending replace its value. Both bases keep only bits 31:8, so their low 8 bits read as zero.
- R8: A divide request with a zero divisor raises cause 5. A divide request with a nonzero divisor raises nothing, and no redirect is issued.
- R9: An unmapped-address fault and a misaligned-access fault each raise cause 4.
- R10: A system call request raises cause 7 through the exception base.
- R11: When several requests arrive together, the winner is chosen in this order: data bus error, divide by zero, system call, breakpoint. Only the winner's vector, return register and enable update take effect.
- R12: When an exception falls in the same cycle as a return or a CSR write to interrupt enable, the exception's enable update wins.
- R13: After reset, enable, pending and both bases read zero, and redirect and the register-file write are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultPc | input | 32 | PC of the instruction raising a request |
| unmappedErr | input | 1 | Data access to an unmapped address |
| misalignErr | input | 1 | Misaligned data access |
| divValid | input | 1 | Unsigned divide or modulo executing |
| divisor | input | 32 | Divisor of that operation |
| syscallReq | input | 1 | System call instruction |
| breakReq | input | 1 | Breakpoint instruction |
| retValid | input | 1 | Branch through a register executing |
| retReg | input | 5 | Register index of that branch |
| irqIn | input | 8 | Interrupt lines, set pending bits |
| csrWe | input | 1 | CSR write strobe |
| csrSel | input | 2 | CSR select |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data for csrSel |
| redirect | output | 1 | Fetch redirect pulse |
| redirectPc | output | 32 | Handler address |
| rfWe | output | 1 | Return-address register write |
| rfAddr | output | 5 | Return-address register index |
| rfData | output | 32 | Saved faulting PC |
| ieOut | output | 3 | Current interrupt-enable state |

## Verification
Three updates can land on interrupt enable in one cycle: an exception's save, a return's restore, and a CSR write. The bench raises an exception in the same cycle as a CSR write to enable, and in another cycle together with a return through register 30. In both cases it expects the enable value that the exception alone would produce. Competing exception requests are issued together in table rows, and each row is judged by the vector address and return register that must belong to the highest-priority request only.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    CAUSE_RESET = 3'd0,
    CAUSE_BREAK = 3'd1,
    CAUSE_IBUS  = 3'd2,
    CAUSE_WATCH = 3'd3,
    CAUSE_DBUS  = 3'd4,
    CAUSE_DIVZ  = 3'd5,
    CAUSE_IRQ   = 3'd6,
    CAUSE_SCALL = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    SEL_IE   = 2'd0,
    SEL_IP   = 2'd1,
    SEL_EBA  = 2'd2,
    SEL_DEBA = 2'd3
  } csr_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   take;
    logic   isBreak;
    cause_e cause;
    logic   retExc;
    logic   retBrk;
    logic   csrWr;
  } trap_strobe_t;

  localparam int EXC_RET_REG = 30;
  localparam int BRK_RET_REG = 31;
  localparam int VEC_SHIFT   = 5;
endpackage

// File: rtl/trap_ctrl_ctl.sv
module trap_ctrl_ctl
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RF_AW = 5
) (
  input  logic             unmappedErr,
  input  logic             misalignErr,
  input  logic             divValid,
  input  logic [XLEN-1:0]  divisor,
  input  logic             syscallReq,
  input  logic             breakReq,
  input  logic             retValid,
  input  logic [RF_AW-1:0] retReg,
  input  logic             csrWe,
  output trap_strobe_t     strobe
);
  logic dbusHit, divHit;

  assign dbusHit = unmappedErr | misalignErr;
  assign divHit  = divValid && (divisor == '0);

  always_comb begin
    strobe = '0;
    strobe.cause = CAUSE_RESET;
    if (dbusHit) begin
      strobe.take  = 1'b1;
      strobe.cause = CAUSE_DBUS;
    end else if (divHit) begin
      strobe.take  = 1'b1;
      strobe.cause = CAUSE_DIVZ;
    end else if (syscallReq) begin
      strobe.take  = 1'b1;
      strobe.cause = CAUSE_SCALL;
    end else if (breakReq) begin
      strobe.take    = 1'b1;
      strobe.isBreak = 1'b1;
      strobe.cause   = CAUSE_BREAK;
    end
    strobe.retExc = retValid && (retReg == RF_AW'(EXC_RET_REG));
    strobe.retBrk = retValid && (retReg == RF_AW'(BRK_RET_REG));
    strobe.csrWr  = csrWe;
  end
endmodule

// File: rtl/trap_ctrl_dp.sv
module trap_ctrl_dp
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IRQ_W = 8,
  parameter int BASE_LSB = 8,
  parameter int RF_AW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  trap_strobe_t     strobe,
  input  logic [XLEN-1:0]  faultPc,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic [1:0]       csrSel,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [XLEN-1:0]  csrRdata,
  output logic             redirect,
  output logic [XLEN-1:0]  redirectPc,
  output logic             rfWe,
  output logic [RF_AW-1:0] rfAddr,
  output logic [XLEN-1:0]  rfData,
  output logic [2:0]       ieOut
);
  localparam int BASE_W = XLEN - BASE_LSB;

  initial begin
    if (BASE_LSB < VEC_SHIFT + 3) $error("base alignment too small for vector table");
  end

  logic [2:0]        ieQ, ieNext;
  logic [IRQ_W-1:0]  ipQ, ipNext;
  logic [BASE_W-1:0] ebaQ, debaQ;
  logic [XLEN-1:0]   vecPc;
  csr_sel_e          sel;

  assign sel = csr_sel_e'(csrSel);
  assign vecPc = {(strobe.isBreak ? debaQ : ebaQ), {BASE_LSB{1'b0}}}
               | (XLEN'(strobe.cause) << VEC_SHIFT);

  always_comb begin
    ieNext = ieQ;
    if (strobe.take)
      ieNext = strobe.isBreak ? {ieQ[0], 2'b00} : {1'b0, ieQ[0], 1'b0};
    else if (strobe.retExc)
      ieNext = {2'b00, ieQ[1]};
    else if (strobe.retBrk)
      ieNext = {2'b00, ieQ[2]};
    else if (strobe.csrWr && sel == SEL_IE)
      ieNext = csrWdata[2:0];
  end

  always_comb begin
    ipNext = ipQ;
    if (strobe.csrWr && sel == SEL_IP)
      ipNext = ipQ & ~csrWdata[IRQ_W-1:0];
    ipNext = ipNext | irqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ        <= '0;
      ipQ        <= '0;
      ebaQ       <= '0;
      debaQ      <= '0;
      redirect   <= 1'b0;
      redirectPc <= '0;
      rfWe       <= 1'b0;
      rfAddr     <= '0;
      rfData     <= '0;
    end else begin
      ieQ <= ieNext;
      ipQ <= ipNext;
      if (strobe.csrWr && sel == SEL_EBA)  ebaQ  <= csrWdata[XLEN-1:BASE_LSB];
      if (strobe.csrWr && sel == SEL_DEBA) debaQ <= csrWdata[XLEN-1:BASE_LSB];
      redirect <= strobe.take;
      rfWe     <= strobe.take;
      if (strobe.take) begin
        redirectPc <= vecPc;
        rfData     <= faultPc;
        rfAddr     <= strobe.isBreak ? RF_AW'(BRK_RET_REG) : RF_AW'(EXC_RET_REG);
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IE:   csrRdata = XLEN'(ieQ);
      SEL_IP:   csrRdata = XLEN'(ipQ);
      SEL_EBA:  csrRdata = {ebaQ, {BASE_LSB{1'b0}}};
      default:  csrRdata = {debaQ, {BASE_LSB{1'b0}}};
    endcase
  end

  assign ieOut = ieQ;

  assert_exc_save_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && !strobe.isBreak |=> redirect && rfWe
      && rfAddr == RF_AW'(EXC_RET_REG) && rfData == $past(faultPc));

  assert_ie_exc_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && !strobe.isBreak |=> ieQ == {1'b0, $past(ieQ[0]), 1'b0});

  assert_brk_save_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && strobe.isBreak |=> redirect && rfAddr == RF_AW'(BRK_RET_REG));

  assert_ie_brk_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && strobe.isBreak |=> ieQ == {$past(ieQ[0]), 2'b00});

  assert_ret_exc_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take && strobe.retExc |=> ieQ == {2'b00, $past(ieQ[1])});

  assert_ip_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.csrWr && sel == SEL_IP |=>
      (ipQ & $past(csrWdata[IRQ_W-1:0]) & ~$past(irqIn)) == '0);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !redirect && !rfWe);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IRQ_W = 8,
  parameter int BASE_LSB = 8,
  parameter int RF_AW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  faultPc,
  input  logic             unmappedErr,
  input  logic             misalignErr,
  input  logic             divValid,
  input  logic [XLEN-1:0]  divisor,
  input  logic             syscallReq,
  input  logic             breakReq,
  input  logic             retValid,
  input  logic [RF_AW-1:0] retReg,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic             csrWe,
  input  logic [1:0]       csrSel,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [XLEN-1:0]  csrRdata,
  output logic             redirect,
  output logic [XLEN-1:0]  redirectPc,
  output logic             rfWe,
  output logic [RF_AW-1:0] rfAddr,
  output logic [XLEN-1:0]  rfData,
  output logic [2:0]       ieOut
);
  trap_strobe_t strobe;

  trap_ctrl_ctl #(.XLEN(XLEN), .RF_AW(RF_AW)) i_ctl (
    .unmappedErr(unmappedErr), .misalignErr(misalignErr),
    .divValid(divValid), .divisor(divisor),
    .syscallReq(syscallReq), .breakReq(breakReq),
    .retValid(retValid), .retReg(retReg), .csrWe(csrWe),
    .strobe(strobe)
  );

  trap_ctrl_dp #(.XLEN(XLEN), .IRQ_W(IRQ_W), .BASE_LSB(BASE_LSB), .RF_AW(RF_AW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .faultPc(faultPc), .irqIn(irqIn),
    .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .redirect(redirect), .redirectPc(redirectPc), .rfWe(rfWe),
    .rfAddr(rfAddr), .rfData(rfData), .ieOut(ieOut)
  );
endmodule

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] faultPc = '0, divisor = '0, csrWdata = '0;
  logic        unmappedErr = 0, misalignErr = 0, divValid = 0, syscallReq = 0, breakReq = 0;
  logic        retValid = 0, csrWe = 0;
  logic [4:0]  retReg = '0;
  logic [7:0]  irqIn = '0;
  logic [1:0]  csrSel = '0;
  logic [31:0] csrRdata, redirectPc, rfData;
  logic        redirect, rfWe;
  logic [4:0]  rfAddr;
  logic [2:0]  ieOut;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_ctrl i_trap_ctrl (
    .clk(clk), .rstN(rstN), .faultPc(faultPc), .unmappedErr(unmappedErr),
    .misalignErr(misalignErr), .divValid(divValid), .divisor(divisor),
    .syscallReq(syscallReq), .breakReq(breakReq), .retValid(retValid),
    .retReg(retReg), .irqIn(irqIn), .csrWe(csrWe), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .redirect(redirect),
    .redirectPc(redirectPc), .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData),
    .ieOut(ieOut)
  );

  typedef struct packed {
    logic        unm, mis, sys, brk, divV;
    logic [31:0] dvs;
    logic [2:0]  ieIn;
    logic        expRedir;
    logic [31:0] expPc;
    logic [4:0]  expAddr;
    logic [2:0]  expIe;
  } vec_t;

  localparam int NV = 10;
  // exception base 0x10000000, debug base 0x20000100
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'd0, 3'b001, 1'b1, 32'h1000_0080, 5'd30, 3'b010},
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'd0, 3'b001, 1'b1, 32'h1000_0080, 5'd30, 3'b010},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'd0, 3'b111, 1'b1, 32'h1000_00A0, 5'd30, 3'b010},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'd5, 3'b001, 1'b0, 32'h0,         5'd0,  3'b001},
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 32'd0, 3'b000, 1'b1, 32'h1000_00E0, 5'd30, 3'b000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'd0, 3'b001, 1'b1, 32'h2000_0120, 5'd31, 3'b100},
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 32'd3, 3'b001, 1'b1, 32'h1000_00E0, 5'd30, 3'b010},
    '{1'b1,1'b0,1'b1,1'b1,1'b1, 32'd0, 3'b001, 1'b1, 32'h1000_0080, 5'd30, 3'b010},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'd0, 3'b110, 1'b1, 32'h1000_00A0, 5'd30, 3'b000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'd0, 3'b110, 1'b1, 32'h2000_0120, 5'd31, 3'b000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic csrWrite(input logic [1:0] s, input logic [31:0] d);
    csrWe = 1; csrSel = s; csrWdata = d;
    tick();
    csrWe = 0; csrWdata = '0;
  endtask

  task automatic csrRead(input logic [1:0] s, output logic [31:0] d);
    csrSel = s; #1; d = csrRdata;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    check("R13 redirect", {31'b0, redirect}, 32'd0);
    check("R13 rfWe", {31'b0, rfWe}, 32'd0);
    rstN = 1;
    for (int s = 0; s < 4; s++) begin
      csrRead(2'(s), rd);
      check("R13 csr", rd, 32'd0);
    end

    // R7 base write keeps bits 31:8
    csrWrite(2'd2, 32'h1234_56FF);
    csrRead(2'd2, rd); check("R7 eba align", rd, 32'h1234_5600);
    csrWrite(2'd2, 32'h1000_0000);
    csrWrite(2'd3, 32'h2000_0155);
    csrRead(2'd3, rd); check("R7 deba align", rd, 32'h2000_0100);

    // vector table: R1 R2 R3 R4 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      csrWrite(2'd0, {29'b0, VECS[i].ieIn});
      faultPc = 32'h4000_0000 + 32'(i * 4);
      unmappedErr = VECS[i].unm; misalignErr = VECS[i].mis;
      syscallReq = VECS[i].sys; breakReq = VECS[i].brk;
      divValid = VECS[i].divV; divisor = VECS[i].dvs;
      tick();
      unmappedErr = 0; misalignErr = 0; syscallReq = 0; breakReq = 0; divValid = 0;
      check("R1/R3/R8/R11 redirect", {31'b0, redirect}, {31'b0, VECS[i].expRedir});
      check("R1/R3 rfWe", {31'b0, rfWe}, {31'b0, VECS[i].expRedir});
      if (VECS[i].expRedir) begin
        check("R1/R3/R9/R10/R11 vector", redirectPc, VECS[i].expPc);
        check("R1/R3/R11 rfAddr", {27'b0, rfAddr}, {27'b0, VECS[i].expAddr});
        check("R1 rfData", rfData, 32'h4000_0000 + 32'(i * 4));
      end
      check("R2/R4 ie", {29'b0, ieOut}, {29'b0, VECS[i].expIe});
      tick();
      check("R1 pulse ends", {31'b0, redirect}, 32'd0);
    end

    // R5 returns
    csrWrite(2'd0, 32'd2);
    retValid = 1; retReg = 5'd30; tick(); retValid = 0;
    check("R5 ret30", {29'b0, ieOut}, 32'd1);
    csrWrite(2'd0, 32'd4);
    retValid = 1; retReg = 5'd31; tick(); retValid = 0;
    check("R5 ret31", {29'b0, ieOut}, 32'd1);
    csrWrite(2'd0, 32'd5);
    retValid = 1; retReg = 5'd5; tick(); retValid = 0;
    check("R5 other reg", {29'b0, ieOut}, 32'd5);
    csrWrite(2'd0, 32'd3);
    retValid = 1; retReg = 5'd30; tick(); retValid = 0;
    check("R5 ret30 clears", {29'b0, ieOut}, 32'd1);

    // R6 pending
    irqIn = 8'hA5; tick(); irqIn = 8'h00;
    csrRead(2'd1, rd); check("R6 set", rd, 32'hA5);
    csrWrite(2'd1, 32'h81);
    csrRead(2'd1, rd); check("R6 w1c", rd, 32'h24);
    irqIn = 8'h04; csrWrite(2'd1, 32'h04); irqIn = 8'h00;
    csrRead(2'd1, rd); check("R6 set wins", rd, 32'h24);
    csrWrite(2'd1, 32'h00);
    csrRead(2'd1, rd); check("R6 zero write", rd, 32'h24);

    // R12 exception vs CSR write / return
    csrWrite(2'd0, 32'd1);
    syscallReq = 1; faultPc = 32'h5000_0000;
    csrWe = 1; csrSel = 2'd0; csrWdata = 32'd7;
    tick();
    syscallReq = 0; csrWe = 0; csrWdata = '0;
    check("R12 exc over csr", {29'b0, ieOut}, 32'd2);
    check("R12 redirect", redirectPc, 32'h1000_00E0);
    csrWrite(2'd0, 32'd1);
    breakReq = 1; retValid = 1; retReg = 5'd30;
    tick();
    breakReq = 0; retValid = 0;
    check("R12 exc over ret", {29'b0, ieOut}, 32'd4);
    check("R12 brk addr", {27'b0, rfAddr}, 32'd31);

    // R7 full replace of enable
    csrWrite(2'd0, 32'd6);
    csrRead(2'd0, rd); check("R7 ie replace", rd, 32'd6);

    // R13 reset mid-run
    rstN = 0; tick(); rstN = 1;
    csrRead(2'd2, rd); check("R13 eba reset", rd, 32'd0);
    check("R13 ie reset", {29'b0, ieOut}, 32'd0);

    finishRun();
  end
endmodule